// File: doc/BRIEF.md
# Eight-Channel Low-Side Driver Fault Tracker

This block keeps the fault state of eight low-side switch channels. Each channel supplies two digital comparator results: one that reports excess current and one that reports a pin voltage too low while the switch is open. Both are qualified by a cycle-counting filter before they are recorded. A recorded excess-current fault turns its channel off and keeps it off until that fault is cleared. The block also takes a die over-temperature indication, a supply undervoltage indication, the current commanded state of every channel, and a single-cycle clear pulse from the command decoder.

The block presents a 16-bit fault word, an active-low summary fault line and an eight-bit mask of channels that must be held off. The output stage combines this mask with the commanded data. Faults clear in two ways. A clear pulse wipes every bit. A change in a channel's commanded state wipes only the bit of the opposite kind: turning the channel off forgets its excess-current fault, and turning it on forgets its open-load fault.

Top module: `lsd_fault_tracker`

## Requirements
- R1: faultReg bit 8+i holds the excess-current flag of channel i and faultReg bit i holds its open-load flag (i = 0..7, channel 0 in the lowest position of each half).
- R2: While dataBits[i] is 1, ocRaw[i] high on OC_CYC consecutive clock edges (175 at the defaults: 3500 ns at 50 MHz) sets faultReg[8+i] on the next edge. A low cycle before the window completes restarts the count.
- R3: forceOff[i] is high whenever faultReg[8+i] is set, and stays high after ocRaw[i] falls, until that bit is cleared.
- R4: Open-load sensing is armed only while dataBits[i] is 0. olRaw[i] high on OL_CYC consecutive edges (850 at the defaults: 17000 ns at 50 MHz) sets faultReg[i] on the next edge. olRaw on a channel that is commanded on has no effect.
- R5: A 1-to-0 change of dataBits[i] clears faultReg[8+i] at that edge. A 0-to-1 change clears faultReg[i]. The bits of other channels are unaffected.
- R6: A high faultClr on a clock edge clears all 16 bits. A fault that qualifies on the same edge wins, so that bit reads 1 afterwards.
- R7: faultN is 0 while any faultReg bit is set, and returns to 1 once all bits are clear (outside over-temperature and undervoltage).
- R8: While otRaw is high (and uvLow low), faultN is 0 and forceOff is all ones. Nothing is recorded, and both outputs return to normal as soon as otRaw falls.
- R9: While uvLow is high, forceOff is all ones and faultN is 1. An edge with uvLow high clears all fault bits and all filter counts.
- R10: After rstN is released, faultReg is 0, forceOff is 0 and faultN is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| uvLow | input | 1 | Supply undervoltage indication, active high |
| otRaw | input | 1 | Die over-temperature indication, active high |
| dataBits | input | 8 | Commanded on state of each channel |
| ocRaw | input | 8 | Per-channel excess-current comparator result |
| olRaw | input | 8 | Per-channel low-pin-voltage comparator result |
| faultClr | input | 1 | Single-cycle clear-all pulse from the command decoder |
| faultReg | output | 16 | Fault word: excess-current flags in [15:8], open-load flags in [7:0] |
| faultN | output | 1 | Summary fault line, active low |
| forceOff | output | 8 | Per-channel mask of channels that must be held off |

## Verification
The critical collision is a clear-all pulse on the same edge on which a filter window completes. The clear must not hide that fault, so the set wins. The bench holds ocRaw high with the channel on for exactly OC_CYC edges, which leaves the count one edge short of setting the bit. It then pulses faultClr on the completing edge and expects the bit to read 1. It repeats the pulse while the comparator stays high and expects the bit to remain 1. The random phase adds clear pulses, commanded-state toggles and comparator toggles at arbitrary moments, and a cycle model built from the requirements judges every edge.

// File: rtl/lsd_fault_pkg.sv
package lsd_fault_pkg;
  localparam int CH = 8;
  localparam int FW = 2 * CH;

  // strobes from control to the fault register datapath
  typedef struct packed {
    logic [CH-1:0] setOc;
    logic [CH-1:0] setOl;
    logic [CH-1:0] clrOc;
    logic [CH-1:0] clrOl;
    logic          clrAll;
    logic          wipe;
  } fltStrobe_t;
endpackage

// File: rtl/lsd_fault_deglitch.sv
module lsd_fault_deglitch #(
  parameter int LIMIT = 175
) (
  input  logic clk,
  input  logic rstN,
  input  logic wipe,
  input  logic raw,
  input  logic arm,
  output logic qual
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  logic [W-1:0] cnt;
  logic         live;

  assign live = raw && arm && !wipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (!live)       cnt <= '0;
    else if (cnt != TOP)  cnt <= cnt + 1'b1;
  end

  // window complete and condition still present this cycle
  assign qual = live && (cnt == TOP);
endmodule

// File: rtl/lsd_fault_ctrl.sv
module lsd_fault_ctrl
  import lsd_fault_pkg::*;
#(
  parameter int OC_CYC = 175,
  parameter int OL_CYC = 850
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          uvLow,
  input  logic [CH-1:0] dataBits,
  input  logic [CH-1:0] ocRaw,
  input  logic [CH-1:0] olRaw,
  input  logic          faultClr,
  output fltStrobe_t    strb
);
  logic [CH-1:0] dataQ;
  logic [CH-1:0] ocQual;
  logic [CH-1:0] olQual;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      dataQ <= '0;
    else if (uvLow) dataQ <= '0;
    else            dataQ <= dataBits;
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    lsd_fault_deglitch #(.LIMIT(OC_CYC)) u_oc (
      .clk(clk), .rstN(rstN), .wipe(uvLow),
      .raw(ocRaw[i]), .arm(dataBits[i]), .qual(ocQual[i])
    );
    lsd_fault_deglitch #(.LIMIT(OL_CYC)) u_ol (
      .clk(clk), .rstN(rstN), .wipe(uvLow),
      .raw(olRaw[i]), .arm(!dataBits[i]), .qual(olQual[i])
    );
  end

  always_comb begin
    strb.setOc  = ocQual;
    strb.setOl  = olQual;
    strb.clrOc  = dataQ & ~dataBits;
    strb.clrOl  = ~dataQ & dataBits;
    strb.clrAll = faultClr;
    strb.wipe   = uvLow;
  end
endmodule

// File: rtl/lsd_fault_dp.sv
module lsd_fault_dp
  import lsd_fault_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  fltStrobe_t    strb,
  input  logic          otRaw,
  input  logic          uvLow,
  output logic [FW-1:0] faultReg,
  output logic          faultN,
  output logic [CH-1:0] forceOff
);
  logic [CH-1:0] ocBits;
  logic [CH-1:0] olBits;
  logic [CH-1:0] ocKill;
  logic [CH-1:0] olKill;

  assign ocKill = strb.clrOc | {CH{strb.clrAll}};
  assign olKill = strb.clrOl | {CH{strb.clrAll}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocBits <= '0;
      olBits <= '0;
    end else if (strb.wipe) begin
      ocBits <= '0;
      olBits <= '0;
    end else begin
      // a fault qualifying on a clearing edge is kept
      ocBits <= (ocBits & ~ocKill) | strb.setOc;
      olBits <= (olBits & ~olKill) | strb.setOl;
    end
  end

  assign faultReg = {ocBits, olBits};
  assign forceOff = ocBits | {CH{otRaw | uvLow}};
  assign faultN   = uvLow | ~((|faultReg) | otRaw);
endmodule

// File: rtl/lsd_fault_tracker.sv
module lsd_fault_tracker
  import lsd_fault_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int OC_NS  = 3500,
  parameter int OL_NS  = 17000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          uvLow,
  input  logic          otRaw,
  input  logic [CH-1:0] dataBits,
  input  logic [CH-1:0] ocRaw,
  input  logic [CH-1:0] olRaw,
  input  logic          faultClr,
  output logic [FW-1:0] faultReg,
  output logic          faultN,
  output logic [CH-1:0] forceOff
);
  localparam int MHZ    = CLK_HZ / 1_000_000;
  localparam int OC_RAW = MHZ * OC_NS / 1000;
  localparam int OL_RAW = MHZ * OL_NS / 1000;
  localparam int OC_CYC = (OC_RAW < 1) ? 1 : OC_RAW;
  localparam int OL_CYC = (OL_RAW < 1) ? 1 : OL_RAW;

  fltStrobe_t strb;

  lsd_fault_ctrl #(.OC_CYC(OC_CYC), .OL_CYC(OL_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .uvLow(uvLow), .dataBits(dataBits),
    .ocRaw(ocRaw), .olRaw(olRaw), .faultClr(faultClr), .strb(strb)
  );

  lsd_fault_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .otRaw(otRaw), .uvLow(uvLow),
    .faultReg(faultReg), .faultN(faultN), .forceOff(forceOff)
  );
endmodule

// File: rtl/lsd_fault_tracker_chk.sv
module lsd_fault_tracker_chk
  import lsd_fault_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          uvLow,
  input logic          otRaw,
  input logic [CH-1:0] dataBits,
  input logic [CH-1:0] ocRaw,
  input logic [CH-1:0] olRaw,
  input logic          faultClr,
  input logic [FW-1:0] faultReg,
  input logic          faultN,
  input logic [CH-1:0] forceOff
);
  p_oc_holds_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (faultReg[FW-1:CH] & ~forceOff) == '0);

  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rstN)
    (faultClr && !uvLow && ocRaw == '0 && olRaw == '0) |=> faultReg == '0);

  p_uv_wipe_r9: assert property (@(posedge clk) disable iff (!rstN)
    uvLow |=> faultReg == '0);

  p_uv_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    uvLow |-> (faultN && forceOff == '1));

  p_thermal_r8: assert property (@(posedge clk) disable iff (!rstN)
    (otRaw && !uvLow) |-> (!faultN && forceOff == '1));

  p_flag_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!uvLow && faultReg != '0) |-> !faultN);

  for (genvar i = 0; i < CH; i++) begin : g_ch
    p_off_clears_oc_r5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(dataBits[i]) |=> !faultReg[CH+i]);
    p_on_clears_ol_r5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(dataBits[i]) |=> !faultReg[i]);
    p_ol_armed_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(faultReg[i]) |-> $past(!dataBits[i]));
  end
endmodule

bind lsd_fault_tracker lsd_fault_tracker_chk u_chk (
  .clk(clk), .rstN(rstN), .uvLow(uvLow), .otRaw(otRaw),
  .dataBits(dataBits), .ocRaw(ocRaw), .olRaw(olRaw), .faultClr(faultClr),
  .faultReg(faultReg), .faultN(faultN), .forceOff(forceOff)
);

// File: tb/lsd_fault_tracker_test.sv
module lsd_fault_tracker_test;
  localparam int OC_CYC = 175;  // 3500 ns at 50 MHz
  localparam int OL_CYC = 850;  // 17000 ns at 50 MHz

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uvLow = 1'b0, otRaw = 1'b0, faultClr = 1'b0;
  logic [7:0] dataBits = '0, ocRaw = '0, olRaw = '0;
  logic [15:0] faultReg;
  logic faultN;
  logic [7:0] forceOff;

  int total = 0;
  int bad = 0;

  // reference state
  int mOcCnt[8];
  int mOlCnt[8];
  logic [7:0] mOc = '0, mOl = '0, mPrev = '0;

  always #10 clk = ~clk;

  lsd_fault_tracker uut (
    .clk(clk), .rstN(rstN), .uvLow(uvLow), .otRaw(otRaw),
    .dataBits(dataBits), .ocRaw(ocRaw), .olRaw(olRaw), .faultClr(faultClr),
    .faultReg(faultReg), .faultN(faultN), .forceOff(forceOff)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expForce();
    return mOc | ((otRaw || uvLow) ? 8'hff : 8'h00);
  endfunction

  function automatic logic expFaultN();
    if (uvLow) return 1'b1;
    return !((|{mOc, mOl}) || otRaw);
  endfunction

  task automatic modelEdge();
    for (int i = 0; i < 8; i++) begin
      if (uvLow) begin
        mOcCnt[i] = 0; mOlCnt[i] = 0;
        mOc[i] = 1'b0; mOl[i] = 1'b0;
      end else begin
        logic qo, ql;
        qo = ocRaw[i] && dataBits[i] && (mOcCnt[i] == OC_CYC);
        ql = olRaw[i] && !dataBits[i] && (mOlCnt[i] == OL_CYC);
        if (ocRaw[i] && dataBits[i]) begin
          if (mOcCnt[i] < OC_CYC) mOcCnt[i]++;
        end else mOcCnt[i] = 0;
        if (olRaw[i] && !dataBits[i]) begin
          if (mOlCnt[i] < OL_CYC) mOlCnt[i]++;
        end else mOlCnt[i] = 0;
        if (faultClr || (mPrev[i] && !dataBits[i])) mOc[i] = 1'b0;
        if (faultClr || (!mPrev[i] && dataBits[i])) mOl[i] = 1'b0;
        if (qo) mOc[i] = 1'b1;
        if (ql) mOl[i] = 1'b1;
      end
    end
    mPrev = uvLow ? 8'h00 : dataBits;
  endtask

  task automatic step();
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    chk("R2 oc half", faultReg[15:8], mOc);
    chk("R4 ol half", faultReg[7:0], mOl);
    chk("R3 forceOff", forceOff, expForce());
    chk("R7 faultN", faultN, expFaultN());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    chk("R10 faultReg", faultReg, 0);
    chk("R10 forceOff", forceOff, 0);
    chk("R10 faultN", faultN, 1);

    // R2/R1/R3/R7: excess current on channel 2
    dataBits = 8'h04; ocRaw = 8'h04;
    repeat (OC_CYC) step();
    chk("R2 one edge short", faultReg, 16'h0000);
    step();
    chk("R1 oc position", faultReg, 16'h0400);
    chk("R3 mask", forceOff, 8'h04);
    chk("R7 flag low", faultN, 0);

    // R2 glitch restarts the window on channel 5
    dataBits = 8'h24; ocRaw = 8'h24;
    repeat (OC_CYC - 1) step();
    ocRaw = 8'h04; step();
    ocRaw = 8'h24;
    repeat (OC_CYC - 1) step();
    chk("R2 glitch restart", faultReg, 16'h0400);

    // R3 mask sticky, R5 off clears oc
    ocRaw = 8'h00;
    repeat (5) step();
    chk("R3 sticky mask", forceOff, 8'h04);
    dataBits = 8'h20; step();
    chk("R5 off clears oc", faultReg, 16'h0000);
    chk("R3 mask released", forceOff, 8'h00);
    chk("R7 flag released", faultN, 1);

    // R4 open load armed only when off (ch1 on -> ignored)
    dataBits = 8'h02; olRaw = 8'h83;
    repeat (OL_CYC + 1) step();
    chk("R4 armed only off", faultReg, 16'h0081);

    // R5 on clears only that channel's ol
    olRaw = 8'h00; dataBits = 8'h03; step();
    chk("R5 on clears ol", faultReg, 16'h0080);

    // R6 clear all
    ocRaw = 8'h02;
    repeat (OC_CYC + 1) step();
    chk("R6 setup", faultReg, 16'h0280);
    ocRaw = 8'h00; step();
    faultClr = 1'b1; step(); faultClr = 1'b0;
    chk("R6 clear all", faultReg, 16'h0000);
    chk("R6 flag released", faultN, 1);

    // R6 clear and qualify on the same edge
    dataBits = 8'h0b; ocRaw = 8'h08;
    repeat (OC_CYC) step();
    chk("R6 pre-collision", faultReg, 16'h0000);
    faultClr = 1'b1; step(); faultClr = 1'b0;
    chk("R6 set wins", faultReg, 16'h0800);
    faultClr = 1'b1; step(); faultClr = 1'b0;
    chk("R6 persistent set wins", faultReg, 16'h0800);
    ocRaw = 8'h00; dataBits = 8'h03; step();
    chk("R5 clear after collision", faultReg, 16'h0000);

    // R8 thermal
    otRaw = 1'b1; step();
    chk("R8 flag low", faultN, 0);
    chk("R8 all off", forceOff, 8'hff);
    chk("R8 not recorded", faultReg, 16'h0000);
    otRaw = 1'b0; step();
    chk("R8 flag back", faultN, 1);
    chk("R8 outputs back", forceOff, 8'h00);

    // R9 undervoltage
    olRaw = 8'h40;
    repeat (OL_CYC + 1) step();
    chk("R9 setup", faultReg, 16'h0040);
    uvLow = 1'b1; otRaw = 1'b1; step();
    chk("R9 wiped", faultReg, 16'h0000);
    chk("R9 flag quiet", faultN, 1);
    chk("R9 all off", forceOff, 8'hff);
    uvLow = 1'b0; otRaw = 1'b0; step();
    chk("R9 window restarted", faultReg, 16'h0000);
    olRaw = 8'h00; step();

    // random phase
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(0, 39) == 0) ocRaw ^= 8'(1 << $urandom_range(0, 7));
      if ($urandom_range(0, 39) == 0) olRaw ^= 8'(1 << $urandom_range(0, 7));
      if ($urandom_range(0, 59) == 0) dataBits ^= 8'(1 << $urandom_range(0, 7));
      faultClr = ($urandom_range(0, 299) == 0);
      if ($urandom_range(0, 499) == 0) otRaw = ~otRaw;
      uvLow = ($urandom_range(0, 1499) == 0);
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule